// File: doc/BRIEF.md
# Multi-Lane ADC Serial Output Shifter

This block takes 16-bit conversion results for two channels, A and B, from a parallel interface that has a valid strobe. It shifts them out on a four-pin data port, pins D3 down to D0, while the active-low chip select is asserted. Each bit is advanced by a rising edge of the serial clock. A lane-mode code selects one of three pin layouts: two pins per channel, one pin per channel, or both channels sent in turn on a single pin. Pins that a layout leaves unused are released to high impedance. An output-enable vector is provided for the pad ring for this purpose.

The chip-select and serial-clock inputs are sampled on the system clock `clk_i`. A latency selector picks the word that a frame carries when chip select falls: either the newest sample held or the one before it. For daisy-chained parts, a feed-through option puts the serial clock itself onto D0.

Top module: `adc_ser_out`

## Requirements
- R1: While `rst_ni` is low, and in the cycles after it until a frame starts, `d_oe_o` is 4'b0000.
- R2: While `cs_ni` is high, `d_oe_o[3:1]` is 0, and `d_oe_o[0]` is 0 unless feed-through is on. Raising `cs_ni` mid-frame and lowering it again restarts the frame at the MSB.
- R3: Lane code 3'b000 enables all four pins. Channel A goes on D3/D2 and channel B on D1/D0, two bits per step. D3 (A) and D1 (B) carry bits 15,13,..,1, and D2 (A) and D0 (B) carry bits 14,12,..,0, so a frame is 8 steps.
- R4: Lane code 3'b101 enables D3 and D1 only (`d_oe_o`=4'b1010). Channel A goes on D3 and channel B on D1, one bit per step, for 16 steps.
- R5: Lane code 3'b110 enables D3 only (`d_oe_o`=4'b1000). All 16 bits of A go out, then all 16 bits of B, for 32 steps.
- R6: Any other lane code behaves exactly as 3'b000.
- R7: A `cs_ni` fall seen at a `clk_i` edge presents the MSB(s) after that edge. Each `sclk_i` rise seen while `cs_ni` is low advances one step after that edge. Once a frame's steps are used up, enabled data pins read 0.
- R8: With `low_lat_i`=0, the frame carries the sample that was one valid strobe older than the newest when chip select fell.
- R9: With `low_lat_i`=1, the frame carries the newest sample strobed before chip select fell.
- R10: With `daisy_clk_i`=1, D0 is enabled and equals `sclk_i` combinationally, whatever the chip-select state.
- R11: The lane code and the frame word are captured at the chip-select fall. Changing `lane_mode_i` mid-frame does not change the pin layout or the bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_a_i | input | 16 | Channel A conversion word |
| smp_b_i | input | 16 | Channel B conversion word |
| lane_mode_i | input | 3 | Pin layout code |
| low_lat_i | input | 1 | 1: newest sample, 0: previous sample |
| daisy_clk_i | input | 1 | Serial clock feed-through on D0 |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| d_o | output | 4 | Data pins D3..D0 |
| d_oe_o | output | 4 | Per-pin output enable, 0 means high impedance |

## Verification
The hardest case to reach is a frame that is cut short and then restarted. This needs chip select to rise after some shifts and fall again, so that both the step counter and the shift state must reload. The bench shifts twice, toggles chip select, and checks that the MSB reappears. A lane-code change in the middle of a frame is also driven after the first step, and the bench confirms that the captured layout still decodes the full word. Each table vector strobes two different samples before the frame, so that only the correct latency choice reproduces the expected words.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam logic [2:0] LANE_CODE_SINGLE = 3'b101;
  localparam logic [2:0] LANE_CODE_SHARED = 3'b110;

  typedef enum logic [1:0] {
    LM_DUAL   = 2'd0,
    LM_SINGLE = 2'd1,
    LM_SHARED = 2'd2
  } lane_map_e;

  function automatic lane_map_e decode_lane(input logic [2:0] code);
    case (code)
      LANE_CODE_SINGLE: return LM_SINGLE;
      LANE_CODE_SHARED: return LM_SHARED;
      default:          return LM_DUAL;
    endcase
  endfunction
endpackage

// File: rtl/adc_smp_hold.sv
module adc_smp_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              low_lat_i,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o
);
  logic [WORD_W-1:0] cur_a_q, cur_b_q, prv_a_q, prv_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_a_q <= '0;
      cur_b_q <= '0;
      prv_a_q <= '0;
      prv_b_q <= '0;
    end else if (valid_i) begin
      prv_a_q <= cur_a_q;
      prv_b_q <= cur_b_q;
      cur_a_q <= a_i;
      cur_b_q <= b_i;
    end
  end

  assign word_a_o = low_lat_i ? cur_a_q : prv_a_q;
  assign word_b_o = low_lat_i ? cur_b_q : prv_b_q;

  // R8 / R9: two-deep history advances on each strobe
  p_hist_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cur_a_q == $past(a_i) && prv_a_q == $past(cur_a_q)));
endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift
  import adc_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_fall_i,
  input  logic              step_i,
  input  lane_map_e         mode_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic              active_o,
  output lane_map_e         mode_o,
  output logic [1:0]        top_a_o,
  output logic [1:0]        top_b_o
);
  localparam int unsigned SR_W  = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] LEN_DUAL   = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] LEN_SINGLE = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_SHARED = CNT_W'(SR_W);

  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             active_q;
  lane_map_e        mode_q;

  always_comb begin
    case (mode_q)
      LM_SINGLE: len = LEN_SINGLE;
      LM_SHARED: len = LEN_SHARED;
      default:   len = LEN_DUAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      mode_q   <= LM_DUAL;
    end else if (cs_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (cs_fall_i) begin
      sr_q     <= {word_a_i, word_b_i};
      cnt_q    <= '0;
      active_q <= 1'b1;
      mode_q   <= mode_i;
    end else if (step_i && active_q && cnt_q < len) begin
      cnt_q <= cnt_q + 1'b1;
      case (mode_q)
        LM_SINGLE: sr_q <= {sr_q[SR_W-2:WORD_W], 1'b0, sr_q[WORD_W-2:0], 1'b0};
        LM_SHARED: sr_q <= {sr_q[SR_W-2:0], 1'b0};
        default:   sr_q <= {sr_q[SR_W-3:WORD_W], 2'b00, sr_q[WORD_W-3:0], 2'b00};
      endcase
    end
  end

  assign active_o = active_q;
  assign mode_o   = mode_q;
  assign top_a_o  = sr_q[SR_W-1 -: 2];
  assign top_b_o  = sr_q[WORD_W-1 -: 2];

  // R7: step counter restarts at frame start and never passes frame length
  p_frame_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (cnt_q == '0 && active_q));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len);
  // R11: layout frozen inside a frame
  p_mode_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !cs_ni && !cs_fall_i) |=> $stable(mode_q));
endmodule

// File: rtl/adc_pin_mux.sv
module adc_pin_mux
  import adc_ser_pkg::*;
(
  input  logic       active_i,
  input  lane_map_e  mode_i,
  input  logic [1:0] top_a_i,
  input  logic [1:0] top_b_i,
  input  logic       daisy_i,
  input  logic       sclk_i,
  output logic [3:0] d_o,
  output logic [3:0] oe_o
);
  logic [3:0] dat, en;

  always_comb begin
    case (mode_i)
      LM_SINGLE: begin
        dat = {top_a_i[1], 1'b0, top_b_i[1], 1'b0};
        en  = 4'b1010;
      end
      LM_SHARED: begin
        dat = {top_a_i[1], 3'b000};
        en  = 4'b1000;
      end
      default: begin
        dat = {top_a_i, top_b_i};
        en  = 4'b1111;
      end
    endcase
    if (!active_i) begin
      dat = 4'b0000;
      en  = 4'b0000;
    end
  end

  assign d_o  = {dat[3:1], daisy_i ? sclk_i : dat[0]};
  assign oe_o = {en[3:1], en[0] | daisy_i};
endmodule

// File: rtl/adc_ser_out.sv
module adc_ser_out
  import adc_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_a_i,
  input  logic [WORD_W-1:0] smp_b_i,
  input  logic [2:0]        lane_mode_i,
  input  logic              low_lat_i,
  input  logic              daisy_clk_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  output logic [3:0]        d_o,
  output logic [3:0]        d_oe_o
);
  logic              cs_q, sclk_q;
  logic              cs_fall, step;
  logic [WORD_W-1:0] word_a, word_b;
  logic              active;
  lane_map_e         mode_cur;
  logic [1:0]        top_a, top_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall = cs_q & ~cs_ni;
  assign step    = sclk_i & ~sclk_q & ~cs_ni;

  adc_smp_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .a_i       (smp_a_i),
    .b_i       (smp_b_i),
    .low_lat_i (low_lat_i),
    .word_a_o  (word_a),
    .word_b_o  (word_b)
  );

  adc_lane_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .cs_fall_i (cs_fall),
    .step_i    (step),
    .mode_i    (decode_lane(lane_mode_i)),
    .word_a_i  (word_a),
    .word_b_i  (word_b),
    .active_o  (active),
    .mode_o    (mode_cur),
    .top_a_o   (top_a),
    .top_b_o   (top_b)
  );

  adc_pin_mux u_mux (
    .active_i (active),
    .mode_i   (mode_cur),
    .top_a_i  (top_a),
    .top_b_i  (top_b),
    .daisy_i  (daisy_clk_i),
    .sclk_i   (sclk_i),
    .d_o      (d_o),
    .oe_o     (d_oe_o)
  );

  // R2: deselect releases data pins one cycle later
  p_cs_high_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (d_oe_o[3:1] == 3'b000));
  // R10: feed-through keeps D0 driven
  p_daisy_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    daisy_clk_i |-> d_oe_o[0]);
endmodule

// File: tb/adc_ser_out_tb.sv
module adc_ser_out_tb;
  typedef struct packed {
    logic [2:0]  mode;
    logic        lat;
    logic [15:0] a0, b0, a1, b1, ea, eb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 16'h1234, 16'hABCD, 16'h5A5A, 16'h0F0F, 16'h1234, 16'hABCD},
    '{3'b000, 1'b1, 16'h8001, 16'h7FFE, 16'hC3C3, 16'h3C3C, 16'hC3C3, 16'h3C3C},
    '{3'b101, 1'b0, 16'hFFFF, 16'h0000, 16'h1111, 16'h2222, 16'hFFFF, 16'h0000},
    '{3'b101, 1'b1, 16'h0000, 16'h0000, 16'hA5A5, 16'h5A5A, 16'hA5A5, 16'h5A5A},
    '{3'b110, 1'b1, 16'h0001, 16'h8000, 16'hDEAD, 16'hBEEF, 16'hDEAD, 16'hBEEF},
    '{3'b110, 1'b0, 16'hCAFE, 16'hF00D, 16'h0000, 16'h0000, 16'hCAFE, 16'hF00D},
    '{3'b011, 1'b0, 16'h6789, 16'h9876, 16'h1357, 16'h2468, 16'h6789, 16'h9876}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_a = '0, smp_b = '0;
  logic [2:0]  lane_mode = 3'b000;
  logic        low_lat = 1'b0, daisy = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [3:0]  d, d_oe;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_ser_out u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_a_i(smp_a),
    .smp_b_i(smp_b), .lane_mode_i(lane_mode), .low_lat_i(low_lat),
    .daisy_clk_i(daisy), .cs_ni(cs_n), .sclk_i(sclk), .d_o(d), .d_oe_o(d_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    smp_valid = 1'b1; smp_a = a; smp_b = b;
    cyc();
    smp_valid = 1'b0;
  endtask

  function automatic int bmode(input logic [2:0] c);
    if (c == 3'b101) return 1;
    if (c == 3'b110) return 2;
    return 0;
  endfunction

  task automatic run_frame(input logic [2:0] code, input logic [15:0] ea,
                           input logic [15:0] eb, input bit flip, input string req);
    int m, steps;
    logic [3:0] eoe;
    logic [15:0] ga, gb;
    m = bmode(code);
    steps = (m == 0) ? 8 : (m == 1) ? 16 : 32;
    eoe = (m == 0) ? 4'hF : (m == 1) ? 4'hA : 4'h8;
    ga = '0; gb = '0;
    lane_mode = code;
    cs_n = 1'b0;
    cyc();
    check({req, " oe"}, {28'd0, d_oe}, {28'd0, eoe});
    for (int k = 0; k < steps; k++) begin
      case (m)
        0: begin
          ga[15-2*k] = d[3]; ga[14-2*k] = d[2];
          gb[15-2*k] = d[1]; gb[14-2*k] = d[0];
        end
        1: begin ga[15-k] = d[3]; gb[15-k] = d[1]; end
        default: if (k < 16) ga[15-k] = d[3]; else gb[31-k] = d[3];
      endcase
      if (flip && k == 0) lane_mode = 3'b110; // R11 mid-frame change
      sclk = 1'b1; cyc();
      sclk = 1'b0; cyc();
    end
    check({req, " word A"}, {16'd0, ga}, {16'd0, ea});
    check({req, " word B"}, {16'd0, gb}, {16'd0, eb});
    check("R7 drained pins", {28'd0, d & d_oe}, 32'd0);
    if (flip) check("R11 oe held", {28'd0, d_oe}, {28'd0, eoe});
    cs_n = 1'b1;
    cyc();
    check("R2 cs high hiz", {28'd0, d_oe}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_tb();
  end

  initial begin
    cyc();
    check("R1 oe in reset", {28'd0, d_oe}, 32'd0);
    rst_n = 1'b1;
    cyc(); cyc();
    check("R1 oe after reset", {28'd0, d_oe}, 32'd0);

    // table: R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      low_lat = VECS[i].lat;
      load(VECS[i].a0, VECS[i].b0);
      load(VECS[i].a1, VECS[i].b1);
      run_frame(VECS[i].mode, VECS[i].ea, VECS[i].eb, 1'b0,
                VECS[i].lat ? "R9 vec" : "R8 vec");
    end

    // R11: lane code changed after first step
    low_lat = 1'b1;
    load(16'h9C3A, 16'h4E71);
    run_frame(3'b101, 16'h9C3A, 16'h4E71, 1'b1, "R11 flip");

    // R2 restart: two steps, deselect, reselect -> MSB again
    load(16'h3FFF, 16'hC000);
    lane_mode = 3'b101;
    cs_n = 1'b0; cyc();
    check("R7 first MSB", {30'd0, d[3], d[1]}, 32'b01);
    for (int k = 0; k < 2; k++) begin
      sclk = 1'b1; cyc(); sclk = 1'b0; cyc();
    end
    check("R7 after two steps", {30'd0, d[3], d[1]}, 32'b10);
    cs_n = 1'b1; cyc();
    cs_n = 1'b0; cyc();
    check("R2 restart MSB", {30'd0, d[3], d[1]}, 32'b01);
    cs_n = 1'b1; cyc();

    // R10 daisy feed-through, deselected and in a frame
    daisy = 1'b1; sclk = 1'b1; #1;
    check("R10 d0 high", {30'd0, d_oe[0], d[0]}, 32'b11);
    sclk = 1'b0; #1;
    check("R10 d0 low", {30'd0, d_oe[0], d[0]}, 32'b10);
    check("R2 oe with daisy", {28'd0, d_oe}, 32'h1);
    lane_mode = 3'b101;
    cs_n = 1'b0; cyc();
    sclk = 1'b1; #1;
    check("R10 in frame", {28'd0, d_oe}, 32'hB);
    check("R10 d0 follows", {31'd0, d[0]}, 32'd1);
    sclk = 1'b0; cyc();
    cs_n = 1'b1; daisy = 1'b0; cyc();
    check("R2 final hiz", {28'd0, d_oe}, 32'd0);

    finish_tb();
  end
endmodule